// File: doc/BRIEF.md
# Folded Four-Lane FIR Filter Engine

This block computes a fixed-point FIR filter whose taps are spread over a small number of parallel multipliers. In each clock cycle, four stored input samples are multiplied by four coefficients. The four products pass through a pipelined two-level adder tree. The tree output then goes into an accumulator. A filter with `TAPS` coefficients therefore needs `TAPS/4` issue cycles, called tap groups, for each output. The output rate is four outputs per `TAPS` clocks: one per clock for four taps and one every second clock for eight taps.

Samples enter through a valid/ready handshake. The engine takes a new sample only once it has issued all tap groups of the previous output. It takes it in the same cycle that the last group issues, so sample intake runs back to back. Coefficients are written one at a time into internal registers through a simple write port. Each finished output appears for one cycle with a valid strobe. All arithmetic wraps modulo 2^`ACC_W`.

Top module: `fir4_fold_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `smp_ready` is 1, `res_valid` is 0 and `res_data` is 0. Every stored sample and every coefficient is 0 after reset.
- R2: Each result equals the sum over k = 0..TAPS-1 of coef[k]·x[n-k], where x[n] is the newest accepted sample and x[n-k] is the sample accepted k acceptances earlier. Samples older than reset count as 0, so an impulse followed by zeros returns coef[0], coef[1], … in turn.
- R3: Products and sums are signed two's complement, and the result is the exact sum reduced modulo 2^ACC_W. It wraps with no saturation.
- R4: After a sample is accepted at a clock edge E, `smp_ready` is 0 until the cycle after edge E+TAPS/4-1 and 1 from then on. With `smp_valid` held high, accepted samples are therefore spaced exactly TAPS/4 clocks apart.
- R5: `res_valid` is a single-cycle pulse. It is 1 exactly in the cycle after clock edge E+TAPS/4+3, where E is the edge that accepted the matching sample, and it is 0 at all other times.
- R6: A sample presented while `smp_ready` is 0 is ignored. It neither enters the sample history nor shows up in any later result.
- R7: With `coef_we` high at a clock edge, `coef_data` is written into coefficient `coef_addr`. Results for samples accepted afterwards use the new value.
- R8: Each result holds only the products of its own sample window. The accumulator loads the first group's sum rather than adding it, so nothing is carried over from the previous output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Input sample is offered |
| smp_data | input | DATA_W | Signed input sample |
| smp_ready | output | 1 | Engine will take a sample at the next edge |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(TAPS) | Coefficient index to write |
| coef_data | input | COEF_W | Signed coefficient value |
| res_valid | output | 1 | One-cycle strobe marking a finished result |
| res_data | output | ACC_W | Signed filter result |

## Verification
The hardest case to reach is an accept that lands in the same cycle as the previous sample's last tap group. In that cycle the delay line shifts while the product registers still capture the old window, and the accumulator must restart cleanly for the new output. The stimulus holds `smp_valid` high for many cycles and changes the data on every clock. This forces back-to-back intake, and the rejected values in between test that refused samples are ignored. Separate scenarios cover the remaining corners. A run of large products of one sign drives the sum past the 16-bit range. A constant input would expose any residue left in the accumulator. A coefficient rewrite between two outputs has to show up in the second one only.

// File: rtl/fir4_fold_pkg.sv
package fir4_fold_pkg;

  // Tag that travels with each tap group through the pipeline
  typedef struct packed {
    logic vld;    // a tap group occupies this stage
    logic first;  // first group of an output sample
    logic last;   // last group of an output sample
  } grp_tag_t;

  // Signed product of two sign-extended operands
  function automatic int tap_product(int a, int b);
    return a * b;
  endfunction

  // Two's complement sum; caller keeps the low bits it needs
  function automatic int wrap_sum(int a, int b);
    return a + b;
  endfunction

  // Position in the delay line of lane k within group g
  function automatic int tap_index(int g, int k, int lanes);
    return g * lanes + k;
  endfunction

endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] taps_o [TAPS]
);

  logic signed [DATA_W-1:0] hist_q [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q[0] <= '0;
    else if (shift_en) hist_q[0] <= din;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[i] <= '0;
      else if (shift_en) hist_q[i] <= hist_q[i-1];
    end
  end

  assign taps_o = hist_q;

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int COEF_W = 8,
  parameter int TAPS   = 8,
  localparam int CA_W  = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [CA_W-1:0]          addr,
  input  logic signed [COEF_W-1:0] wdata,
  output logic signed [COEF_W-1:0] coef_o [TAPS]
);

  logic signed [COEF_W-1:0] coef_q [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coef_q[i] <= '0;
      else if (we && (addr == CA_W'(i))) coef_q[i] <= wdata;
    end
  end

  assign coef_o = coef_q;

endmodule

// File: rtl/fir_group_seq.sv
module fir_group_seq
  import fir4_fold_pkg::*;
#(
  parameter int GROUPS = 2,
  localparam int GI_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  output logic            ready,
  output logic [GI_W-1:0] grp_idx,
  output grp_tag_t        tag
);

  logic            busy_q;
  logic [GI_W-1:0] gcnt_q;
  logic            at_last;

  assign at_last = busy_q && (gcnt_q == GI_W'(GROUPS - 1));
  assign ready   = !busy_q || at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gcnt_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      gcnt_q <= '0;
    end else if (at_last) begin
      busy_q <= 1'b0;
      gcnt_q <= '0;
    end else if (busy_q) begin
      gcnt_q <= gcnt_q + 1'b1;
    end
  end

  assign grp_idx   = gcnt_q;
  assign tag.vld   = busy_q;
  assign tag.first = busy_q && (gcnt_q == '0);
  assign tag.last  = at_last;

endmodule

// File: rtl/fir_mul_stage.sv
module fir_mul_stage
  import fir4_fold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 16,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  grp_tag_t                 tag_i,
  input  logic signed [DATA_W-1:0] a_i [LANES],
  input  logic signed [COEF_W-1:0] b_i [LANES],
  output grp_tag_t                 tag_o,
  output logic signed [ACC_W-1:0]  p_o [LANES]
);

  grp_tag_t tag_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    int                      full;
    logic signed [ACC_W-1:0] prod_q;

    always_comb full = tap_product(int'(a_i[k]), int'(b_i[k]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else prod_q <= full[ACC_W-1:0];
    end

    assign p_o[k] = prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else tag_q <= tag_i;
  end

  assign tag_o = tag_q;

endmodule

// File: rtl/fir_adder_tree.sv
module fir_adder_tree
  import fir4_fold_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int LANES   = 4,
  localparam int LEVELS = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  grp_tag_t                tag_i,
  input  logic signed [ACC_W-1:0] in_i [LANES],
  output grp_tag_t                tag_o,
  output logic signed [ACC_W-1:0] sum_o
);

  // One registered level per halving of the operand count
  for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
    localparam int CNT = LANES >> lv;
    logic signed [ACC_W-1:0] node [CNT];
    grp_tag_t                tag;

    if (lv == 0) begin : g_in
      assign node = in_i;
      assign tag  = tag_i;
    end else begin : g_add
      for (genvar j = 0; j < CNT; j++) begin : g_pair
        int pair_sum;
        always_comb pair_sum = wrap_sum(int'(g_lvl[lv-1].node[2*j]),
                                        int'(g_lvl[lv-1].node[2*j+1]));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) node[j] <= '0;
          else node[j] <= pair_sum[ACC_W-1:0];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag <= '0;
        else tag <= g_lvl[lv-1].tag;
      end
    end
  end

  assign sum_o = g_lvl[LEVELS].node[0];
  assign tag_o = g_lvl[LEVELS].tag;

endmodule

// File: rtl/fir_accum.sv
module fir_accum
  import fir4_fold_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  grp_tag_t                tag_i,
  input  logic signed [ACC_W-1:0] sum_i,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_data
);

  logic signed [ACC_W-1:0] acc_q;
  logic                    done_q;
  int                      run_sum;

  always_comb run_sum = wrap_sum(int'(acc_q), int'(sum_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= tag_i.vld && tag_i.last;
      if (tag_i.vld) begin
        if (tag_i.first) acc_q <= sum_i;
        else acc_q <= run_sum[ACC_W-1:0];
      end
    end
  end

  assign res_valid = done_q;
  assign res_data  = acc_q;

endmodule

// File: rtl/fir4_fold_engine.sv
module fir4_fold_engine
  import fir4_fold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 16,
  parameter int TAPS   = 8,
  parameter int LANES  = 4,
  localparam int CA_W  = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic                     smp_ready,
  input  logic                     coef_we,
  input  logic [CA_W-1:0]          coef_addr,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     res_valid,
  output logic signed [ACC_W-1:0]  res_data
);

  localparam int GROUPS = TAPS / LANES;
  localparam int LEVELS = $clog2(LANES);
  localparam int GI_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  // Named internal events for the checker
  logic                     accept_evt;
  logic                     last_issue_evt;
  logic signed [DATA_W-1:0] dl_head;

  logic signed [DATA_W-1:0] dl_taps [TAPS];
  logic signed [COEF_W-1:0] coefs   [TAPS];
  logic signed [DATA_W-1:0] mul_a   [LANES];
  logic signed [COEF_W-1:0] mul_b   [LANES];
  logic signed [ACC_W-1:0]  prods   [LANES];
  logic signed [ACC_W-1:0]  tree_sum;
  logic [GI_W-1:0]          grp_idx;
  grp_tag_t                 tag_issue, tag_mul, tag_tree;

  assign accept_evt     = smp_valid && smp_ready;
  assign last_issue_evt = tag_issue.last;
  assign dl_head        = dl_taps[0];

  fir_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_dline (
    .clk(clk), .rst_n(rst_n), .shift_en(accept_evt), .din(smp_data), .taps_o(dl_taps)
  );

  fir_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS)) u_coefs (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr), .wdata(coef_data),
    .coef_o(coefs)
  );

  fir_group_seq #(.GROUPS(GROUPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept_evt), .ready(smp_ready),
    .grp_idx(grp_idx), .tag(tag_issue)
  );

  // Route the current group's window onto the lanes
  for (genvar k = 0; k < LANES; k++) begin : g_route
    always_comb begin
      mul_a[k] = dl_taps[tap_index(int'(grp_idx), k, LANES)];
      mul_b[k] = coefs[tap_index(int'(grp_idx), k, LANES)];
    end
  end

  fir_mul_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .LANES(LANES)) u_mul (
    .clk(clk), .rst_n(rst_n), .tag_i(tag_issue), .a_i(mul_a), .b_i(mul_b),
    .tag_o(tag_mul), .p_o(prods)
  );

  fir_adder_tree #(.ACC_W(ACC_W), .LANES(LANES)) u_tree (
    .clk(clk), .rst_n(rst_n), .tag_i(tag_mul), .in_i(prods),
    .tag_o(tag_tree), .sum_o(tree_sum)
  );

  fir_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tag_i(tag_tree), .sum_i(tree_sum),
    .res_valid(res_valid), .res_data(res_data)
  );

endmodule

// File: rtl/fir4_fold_checks.sv
module fir4_fold_checks #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16,
  parameter int GROUPS = 2,
  parameter int LAT    = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_ready,
  input logic                     res_valid,
  input logic signed [ACC_W-1:0]  res_data,
  input logic                     accept_evt,
  input logic                     last_issue_evt,
  input logic signed [DATA_W-1:0] dl_head
);

  // Delayed copy of the last-group event, one stage per pipeline register
  logic [LAT-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else lat_q <= {lat_q[LAT-2:0], last_issue_evt};
  end

  // R1: ready and idle outputs right after reset release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (smp_ready && !res_valid && res_data == '0));

  // R4: ready drops after an accept when more than one group is needed
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((GROUPS > 1) && accept_evt) |=> !smp_ready);

  // R5: result strobe follows the last issued group by the pipeline depth
  p_res_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == lat_q[LAT-1]);

  // R5: strobe lasts one cycle
  p_res_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((GROUPS > 1) && res_valid) |=> !res_valid);

  // R6: newest stored sample only changes on an accept
  p_hold_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> $stable(dl_head));

endmodule

bind fir4_fold_engine fir4_fold_checks #(
  .DATA_W(DATA_W), .ACC_W(ACC_W), .GROUPS(GROUPS), .LAT(LEVELS + 2)
) i_checks (
  .clk(clk), .rst_n(rst_n), .smp_ready(smp_ready), .res_valid(res_valid),
  .res_data(res_data), .accept_evt(accept_evt), .last_issue_evt(last_issue_evt),
  .dl_head(dl_head)
);

// File: tb/test_fir4_fold_engine.sv
module test_fir4_fold_engine;

  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int ACC_W  = 16;
  localparam int TAPS   = 8;
  localparam int LANES  = 4;
  localparam int G      = TAPS / LANES;
  localparam int CA_W   = $clog2(TAPS);

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     smp_valid = 1'b0;
  logic signed [DATA_W-1:0] smp_data = '0;
  logic                     smp_ready;
  logic                     coef_we = 1'b0;
  logic [CA_W-1:0]          coef_addr = '0;
  logic signed [COEF_W-1:0] coef_data = '0;
  logic                     res_valid;
  logic signed [ACC_W-1:0]  res_data;

  fir4_fold_engine #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
                     .TAPS(TAPS), .LANES(LANES)) i_fir4_fold_engine (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .res_valid(res_valid), .res_data(res_data)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cyc = 0;
  int    ready_from = 0;
  string cur_req = "R2";
  int    mh [TAPS];
  int    mc [TAPS];
  int    exp_val [$];
  int    exp_due [$];
  string exp_req [$];

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(string req, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // Reference model, run away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      // R5: strobe timing, R2/R3/R6/R7/R8: value
      if (exp_due.size() > 0 && exp_due[0] == cyc) begin
        check("R5", int'(res_valid), 1);
        check(exp_req[0], int'(res_data), exp_val[0]);
        void'(exp_due.pop_front());
        void'(exp_val.pop_front());
        void'(exp_req.pop_front());
      end else if (res_valid) begin
        check("R5", 1, 0);
      end
      // R4: ready pattern
      check("R4", int'(smp_ready), (cyc >= ready_from) ? 1 : 0);
      if (coef_we) mc[coef_addr] = int'(coef_data);
      if (smp_valid && smp_ready) begin
        int acc;
        for (int k = TAPS - 1; k > 0; k--) mh[k] = mh[k-1];
        mh[0] = int'(smp_data);
        acc = 0;
        for (int k = 0; k < TAPS; k++) acc += mh[k] * mc[k];
        acc = int'($signed(acc[ACC_W-1:0]));
        exp_val.push_back(acc);
        exp_due.push_back(cyc + G + 4);
        exp_req.push_back(cur_req);
        ready_from = cyc + G;
      end
    end
  end

  task automatic load_coef(int idx, int val);
    @(posedge clk); #2;
    coef_we = 1'b1; coef_addr = CA_W'(idx); coef_data = COEF_W'(val);
    @(posedge clk); #2;
    coef_we = 1'b0;
  endtask

  task automatic send(int val);
    @(posedge clk); #2;
    smp_valid = 1'b1; smp_data = DATA_W'(val);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    @(posedge clk); #2;
    smp_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (G + 10) @(posedge clk);
    check("R5", exp_due.size(), 0);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", int'(smp_ready), 1);
    check("R1", int'(res_valid), 0);
    check("R1", int'(res_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(smp_ready), 1);
    check("R1", int'(res_valid), 0);
  endtask

  task automatic t_impulse_r2();
    int cv [TAPS] = '{3, -5, 7, -11, 13, 17, -19, 23};
    cur_req = "R2";
    for (int k = 0; k < TAPS; k++) load_coef(k, cv[k]);
    send(1);
    for (int k = 1; k < TAPS + 2; k++) send(0);
    drain();
  endtask

  task automatic t_wrap_r3();
    cur_req = "R3";
    for (int k = 0; k < TAPS; k++) load_coef(k, 127);
    for (int k = 0; k < TAPS; k++) send(-128);
    drain();
    for (int k = 0; k < TAPS; k++) load_coef(k, -128);
    for (int k = 0; k < TAPS; k++) send(-128);
    drain();
  endtask

  task automatic t_stream_r6();
    cur_req = "R6";
    for (int k = 0; k < TAPS; k++) load_coef(k, k - 3);
    @(posedge clk); #2;
    smp_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      smp_data = DATA_W'(i * 13 - 50);
      @(posedge clk); #2;
    end
    smp_valid = 1'b0;
    drain();
  endtask

  task automatic t_reload_r7();
    cur_req = "R7";
    for (int k = 0; k < TAPS; k++) load_coef(k, 2);
    send(5); send(-7);
    drain();
    load_coef(0, -100);
    load_coef(TAPS - 1, 60);
    send(9); send(4);
    drain();
  endtask

  task automatic t_fresh_r8();
    cur_req = "R8";
    for (int k = 0; k < TAPS; k++) load_coef(k, 1);
    for (int i = 0; i < 3 * TAPS; i++) send(10);
    drain();
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) begin mh[k] = 0; mc[k] = 0; end
    t_reset_r1();
    t_impulse_r2();
    t_wrap_r3();
    t_stream_r6();
    t_reload_r7();
    t_fresh_r8();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

endmodule